// File: doc/BRIEF.md
# Triggered Timer Counter Core

This block is the time base of a timer. An up-counter advances on prescaled ticks of either the system clock or an external clock input. It returns to zero after it reaches a programmable modulo, and on that wrap it raises an overflow flag. An interrupt output follows the flag when the interrupt is enabled. The counter value is driven continuously on a bus for the channel logic next to the block.

Trigger control selects one of sixteen trigger inputs. Depending on the control bits, a rising edge on the selected trigger can start the counter or reload it to zero, and a high level can pause it. Further control bits make the counter halt after its first wrap, and pause it in doze or debug mode. Disabling the counter is acknowledged: after software writes the source field to zero, the field keeps reading the old source until the count clock has actually been released.

Software reaches the block through a flat register port with four word addresses. Writes take one cycle, and reads return combinationally on `rd_data`.

Top module: `trig_timer_core`

## Requirements
- R1: After reset the count reads 0, the overflow flag and `ovf_irq` are 0, the control word reads 0 and the modulo register (address 1) reads all ones.
- R2: Control word (address 0) bits [1:0] select the source: 0 is off, 1 is the system clock (a tick on every cycle), 2 is rising edges of `ext_clk`, and 3 is stored as 0. After a nonzero source is written to a stopped counter, the count first advances on the second clock edge after the write edge.
- R3: Control bits [4:2] hold a prescale exponent N. The count advances once every 2^N source ticks. The prescaler restarts from zero whenever the counter is not running or is reloaded.
- R4: On an advance at which the count equals the modulo, the count goes to 0 and the overflow flag (status word at address 2, bit 8) is set. Otherwise the count increments.
- R5: Writing the status word with bit 8 at 1 clears the flag, and writing 0 there leaves it unchanged. If an overflow falls in the same cycle as the clear, the flag stays set.
- R6: `ovf_irq` is high exactly while the flag and the enable at control bit 15 are both 1.
- R7: With control bit 9 set, an enabled counter holds until a rising edge of the selected trigger is seen. It first advances on the edge after that detection. A disable rearms this wait.
- R8: With control bit 10 set, a rising edge of the selected trigger on an enabled, non-halted counter sets the count to 0 on that edge. This takes priority over an overflow in the same cycle, which then neither wraps nor sets the flag.
- R9: With control bit 11 set, the count and the prescaler hold for every cycle in which the selected trigger is high.
- R10: With control bit 12 set, the first overflow halts the counter at 0. It stays halted, and ignores reload triggers, until the source field has been brought to 0 and acknowledged.
- R11: Control bit 13 makes `doze_mode` pause the counter. While control bit 14 is 0, `dbg_mode` pauses the counter; while it is 1, debug has no effect.
- R12: Control bits [8:5] select which bit of `trig_in` is the trigger. Edges on the other bits have no effect.
- R13: After the source field is written to 0, the counter stops advancing at once. Control bits [1:0] keep reading the previous source until that source produces its next tick, and read 0 from the following cycle.
- R14: The count value is readable at address 3 and is driven on `count_val` at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write word address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 2 | Register read word address |
| rd_data | output | DATA_W | Combinational register read data |
| ext_clk | input | 1 | External count clock, sampled by clk |
| trig_in | input | 16 | Trigger sources |
| dbg_mode | input | 1 | Debug mode indication |
| doze_mode | input | 1 | Doze mode indication |
| count_val | output | CNT_W | Current counter value |
| ovf_irq | output | 1 | Overflow interrupt |

## Verification
Two pairs of functions can collide in one cycle. The first is an overflow that sets the flag while software clears it. The second is a trigger reload while the count sits at the modulo. The bench provokes the first by writing the clear bit on every cycle while a short modulo wraps repeatedly. It provokes the second with reload pulses at shifting intervals against a small modulo, so that some pulses land on the wrap. A behavioural model in the bench is stepped on every edge and judges each cycle: the flag must survive a clear that coincides with an overflow, and a reload must win over the wrap.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int EXP_W     = 3;
  localparam int SEL_W     = 4;
  localparam int NUM_TRIG  = 1 << SEL_W;
  localparam int PRE_W     = (1 << EXP_W) - 1;
  localparam int ADDR_W    = 2;
  localparam int CTRL_W    = 16;

  localparam int POS_EXP   = 2;
  localparam int POS_SEL   = POS_EXP + EXP_W;
  localparam int POS_SOT   = POS_SEL + SEL_W;
  localparam int POS_ROT   = POS_SOT + 1;
  localparam int POS_POT   = POS_ROT + 1;
  localparam int POS_HOO   = POS_POT + 1;
  localparam int POS_DOZE  = POS_HOO + 1;
  localparam int POS_DBG   = POS_DOZE + 1;
  localparam int POS_IE    = POS_DBG + 1;
  localparam int STAT_OVF  = 8;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_MOD  = 2'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd2;
  localparam logic [ADDR_W-1:0] A_CNT  = 2'd3;

  typedef enum logic [1:0] {
    SRC_OFF = 2'd0,
    SRC_SYS = 2'd1,
    SRC_EXT = 2'd2
  } src_e;

  typedef struct packed {
    logic             ovf_ie;
    logic             dbg_run;
    logic             doze_hold;
    logic             halt_ovf;
    logic             pause_trg;
    logic             reload_trg;
    logic             start_trg;
    logic [SEL_W-1:0] sel;
    logic [EXP_W-1:0] exp;
    src_e             mode;
  } ctrl_t;

  function automatic ctrl_t ctrl_decode(input logic [CTRL_W-1:0] d);
    ctrl_t c;
    c.mode       = (d[1:0] == 2'd3) ? SRC_OFF : src_e'(d[1:0]);
    c.exp        = d[POS_EXP +: EXP_W];
    c.sel        = d[POS_SEL +: SEL_W];
    c.start_trg  = d[POS_SOT];
    c.reload_trg = d[POS_ROT];
    c.pause_trg  = d[POS_POT];
    c.halt_ovf   = d[POS_HOO];
    c.doze_hold  = d[POS_DOZE];
    c.dbg_run    = d[POS_DBG];
    c.ovf_ie     = d[POS_IE];
    return c;
  endfunction

  function automatic logic [CTRL_W-1:0] ctrl_image(input ctrl_t c, input src_e act);
    logic [CTRL_W-1:0] img;
    img                    = '0;
    img[1:0]               = act;
    img[POS_EXP +: EXP_W]  = c.exp;
    img[POS_SEL +: SEL_W]  = c.sel;
    img[POS_SOT]           = c.start_trg;
    img[POS_ROT]           = c.reload_trg;
    img[POS_POT]           = c.pause_trg;
    img[POS_HOO]           = c.halt_ovf;
    img[POS_DOZE]          = c.doze_hold;
    img[POS_DBG]           = c.dbg_run;
    img[POS_IE]            = c.ovf_ie;
    return img;
  endfunction

  function automatic logic presc_hit(input logic [PRE_W-1:0] pre, input logic [EXP_W-1:0] e);
    logic [PRE_W-1:0] mask;
    mask = '0;
    for (int i = 0; i < PRE_W; i++) begin
      if (i < int'(e)) mask[i] = 1'b1;
    end
    return (pre & mask) == mask;
  endfunction
endpackage

// File: rtl/tmr_regs.sv
`timescale 1ns/1ps
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  src_e              act_mode,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              wrap_evt,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  modulo,
  output logic              ovf_flag,
  output logic              irq,
  output logic [DATA_W-1:0] rd_data
);
  logic stat_clr;
  logic unused_wdata;

  assign unused_wdata = ^wr_data;
  assign stat_clr     = wr_en && (wr_addr == A_STAT) && wr_data[STAT_OVF];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= '0;
      modulo   <= '1;
      ovf_flag <= 1'b0;
    end else begin
      if (wr_en && wr_addr == A_CTRL) ctrl   <= ctrl_decode(wr_data[CTRL_W-1:0]);
      if (wr_en && wr_addr == A_MOD)  modulo <= wr_data[CNT_W-1:0];
      if (wrap_evt)      ovf_flag <= 1'b1;
      else if (stat_clr) ovf_flag <= 1'b0;
    end
  end

  assign irq = ovf_flag & ctrl.ovf_ie;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL:  rd_data[CTRL_W-1:0] = ctrl_image(ctrl, act_mode);
      A_MOD:   rd_data[CNT_W-1:0]  = modulo;
      A_STAT:  rd_data[STAT_OVF]   = ovf_flag;
      default: rd_data[CNT_W-1:0]  = cnt;
    endcase
  end

  assert_ovf_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> ovf_flag);

  assert_w1c_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !wrap_evt) |=> !ovf_flag);
endmodule

// File: rtl/tmr_gate.sv
`timescale 1ns/1ps
module tmr_gate
  import tmr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  ctrl_t               ctrl,
  input  logic                ext_clk,
  input  logic [NUM_TRIG-1:0] trig_in,
  input  logic                dbg_mode,
  input  logic                doze_mode,
  input  logic                wrap_evt,
  output src_e                act_mode,
  output logic                run_ok,
  output logic                adv,
  output logic                reload
);
  logic ext_prev, trg_prev, started, halted;
  logic src_tick, trg_lvl, trg_evt, paused, enabled;
  logic unused_ctrl;

  assign unused_ctrl = ^{ctrl.exp, ctrl.ovf_ie};

  assign trg_lvl = trig_in[ctrl.sel];
  assign trg_evt = trg_lvl & ~trg_prev;

  always_comb begin
    case (act_mode)
      SRC_SYS: src_tick = 1'b1;
      SRC_EXT: src_tick = ext_clk & ~ext_prev;
      default: src_tick = 1'b0;
    endcase
  end

  assign enabled = (ctrl.mode != SRC_OFF) && (act_mode != SRC_OFF);
  assign run_ok  = enabled && (started || !ctrl.start_trg) && !halted;
  assign paused  = (ctrl.pause_trg & trg_lvl)
                 | (ctrl.doze_hold & doze_mode)
                 | (~ctrl.dbg_run & dbg_mode);
  assign adv     = run_ok & ~paused & src_tick;
  assign reload  = trg_evt & ctrl.reload_trg & enabled & ~halted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_mode <= SRC_OFF;
      ext_prev <= 1'b0;
      trg_prev <= 1'b0;
      started  <= 1'b0;
      halted   <= 1'b0;
    end else begin
      ext_prev <= ext_clk;
      trg_prev <= trg_lvl;
      if (ctrl.mode != SRC_OFF) act_mode <= ctrl.mode;
      else if (src_tick)        act_mode <= SRC_OFF;
      if (act_mode == SRC_OFF)  started <= 1'b0;
      else if (trg_evt)         started <= 1'b1;
      if (act_mode == SRC_OFF)                halted <= 1'b0;
      else if (wrap_evt && ctrl.halt_ovf)     halted <= 1'b1;
    end
  end

  assert_disable_waits_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.mode == SRC_OFF && act_mode != SRC_OFF && !src_tick) |=> act_mode == $past(act_mode));

  assert_halt_sticks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && act_mode != SRC_OFF) |=> halted);
endmodule

// File: rtl/tmr_count.sv
`timescale 1ns/1ps
module tmr_count
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_ok,
  input  logic             adv,
  input  logic             reload,
  input  logic [EXP_W-1:0] exp_sel,
  input  logic [CNT_W-1:0] modulo,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap_evt
);
  logic [PRE_W-1:0] pre;
  logic             hit;

  assign hit      = adv && presc_hit(pre, exp_sel);
  assign wrap_evt = hit && (cnt == modulo) && !reload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0;
      cnt <= '0;
    end else begin
      if (reload || !run_ok) pre <= '0;
      else if (adv)          pre <= pre + 1'b1;
      if (reload)            cnt <= '0;
      else if (wrap_evt)     cnt <= '0;
      else if (hit)          cnt <= cnt + 1'b1;
    end
  end

  assert_reload_zeroes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> cnt == '0);

  assert_wrap_to_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> cnt == '0);

  assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !reload) |=> $stable(cnt));
endmodule

// File: rtl/trig_timer_core.sv
`timescale 1ns/1ps
module trig_timer_core
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [DATA_W-1:0]   rd_data,
  input  logic                ext_clk,
  input  logic [NUM_TRIG-1:0] trig_in,
  input  logic                dbg_mode,
  input  logic                doze_mode,
  output logic [CNT_W-1:0]    count_val,
  output logic                ovf_irq
);
  ctrl_t            ctrl;
  src_e             act_mode;
  logic [CNT_W-1:0] modulo;
  logic [CNT_W-1:0] cnt;
  logic             wrap_evt, run_ok, adv, reload, ovf_flag;

  tmr_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .act_mode(act_mode), .cnt(cnt), .wrap_evt(wrap_evt),
    .ctrl(ctrl), .modulo(modulo), .ovf_flag(ovf_flag), .irq(ovf_irq), .rd_data(rd_data)
  );

  tmr_gate u_gate (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .ext_clk(ext_clk), .trig_in(trig_in),
    .dbg_mode(dbg_mode), .doze_mode(doze_mode), .wrap_evt(wrap_evt),
    .act_mode(act_mode), .run_ok(run_ok), .adv(adv), .reload(reload)
  );

  tmr_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .run_ok(run_ok), .adv(adv), .reload(reload),
    .exp_sel(ctrl.exp), .modulo(modulo), .cnt(cnt), .wrap_evt(wrap_evt)
  );

  assign count_val = cnt;

  assert_irq_needs_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && ctrl.ovf_ie) |=> ovf_irq);
endmodule

// File: tb/tb_trig_timer_core.sv
`timescale 1ns/1ps
module tb_trig_timer_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        ext_clk = 1'b0;
  logic [15:0] trig_in = '0;
  logic        dbg_mode = 1'b0;
  logic        doze_mode = 1'b0;
  logic [15:0] count_val;
  logic        ovf_irq;

  always #10 clk = ~clk;

  trig_timer_core dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ext_clk(ext_clk), .trig_in(trig_in),
    .dbg_mode(dbg_mode), .doze_mode(doze_mode), .count_val(count_val), .ovf_irq(ovf_irq)
  );

  int    n_chk = 0;
  int    n_err = 0;
  bit    done = 1'b0;
  string phase = "R1";

  // behavioural reference state
  int m_ctrl, m_mod, m_act, m_pre, m_cnt;
  bit m_flag, m_started, m_halted, m_tprev, m_eprev;
  int md, ex, sl, per;
  bit lvl, evt, stick, run, pz, adv, rel, hit, wrp, clr;

  task automatic check(input string tag, input logic [31:0] a, input logic [31:0] e);
    n_chk++;
    if (a !== e) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
    end
  endtask

  function automatic logic [31:0] mk(int mode, int e, int s, bit sot, bit rot, bit pot,
                                     bit hoo, bit dz, bit dr, bit ie);
    return 32'(mode) | (32'(e) << 2) | (32'(s) << 5) | (32'(sot) << 9) | (32'(rot) << 10)
         | (32'(pot) << 11) | (32'(hoo) << 12) | (32'(dz) << 13) | (32'(dr) << 14)
         | (32'(ie) << 15);
  endfunction

  function automatic logic [31:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0:    return 32'((m_ctrl & 32'hFFFC) | m_act);
      2'd1:    return 32'(m_mod);
      2'd2:    return 32'(m_flag) << 8;
      default: return 32'(m_cnt);
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_mod = 32'hFFFF; m_act = 0; m_pre = 0; m_cnt = 0;
      m_flag = 0; m_started = 0; m_halted = 0; m_tprev = 0; m_eprev = 0;
    end else begin
      md    = m_ctrl & 3;
      ex    = (m_ctrl >> 2) & 7;
      sl    = (m_ctrl >> 5) & 15;
      per   = 1 << ex;
      lvl   = trig_in[sl];
      evt   = lvl && !m_tprev;
      stick = (m_act == 1) || (m_act == 2 && ext_clk && !m_eprev);
      run   = md != 0 && m_act != 0 && (m_started || !m_ctrl[9]) && !m_halted;
      pz    = (m_ctrl[11] && lvl) || (m_ctrl[13] && doze_mode) || (!m_ctrl[14] && dbg_mode);
      adv   = run && !pz && stick;
      rel   = evt && m_ctrl[10] && md != 0 && m_act != 0 && !m_halted;
      hit   = adv && ((m_pre % per) == per - 1);
      wrp   = hit && m_cnt == m_mod && !rel;
      clr   = wr_en && wr_addr == 2 && wr_data[8];
      if (rel) m_cnt = 0;
      else if (wrp) m_cnt = 0;
      else if (hit) m_cnt = (m_cnt + 1) & 32'hFFFF;
      if (rel || !run) m_pre = 0;
      else if (adv) m_pre = (m_pre + 1) % 128;
      if (wrp) m_flag = 1; else if (clr) m_flag = 0;
      if (m_act == 0) m_halted = 0; else if (wrp && m_ctrl[12]) m_halted = 1;
      if (m_act == 0) m_started = 0; else if (evt) m_started = 1;
      if (md != 0) m_act = md; else if (stick) m_act = 0;
      m_tprev = lvl;
      m_eprev = ext_clk;
      if (wr_en && wr_addr == 0) begin
        m_ctrl = wr_data & 32'hFFFF;
        if ((m_ctrl & 3) == 3) m_ctrl = m_ctrl & 32'hFFFC;
      end
      if (wr_en && wr_addr == 1) m_mod = wr_data & 32'hFFFF;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check({phase, " count"}, 32'(count_val), 32'(m_cnt));
      check({phase, " irq"}, 32'(ovf_irq), 32'(m_flag && m_ctrl[15]));
      check({phase, " rd_data"}, rd_data, exp_rd(rd_addr));
    end
  end

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #3; end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick(1);
    wr_en = 1'b0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [15:0] cap;
    tick(3);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 count after reset", 32'(count_val), 0);
    check("R1 irq after reset", 32'(ovf_irq), 0);
    check("R1 control after reset", rd_data, 0);
    tick(1);
    rd_addr = 2'd1;
    @(negedge clk);
    check("R1 modulo after reset", rd_data, 32'hFFFF);
    tick(1);

    phase = "R2";
    rd_addr = 2'd3;
    wr(2'd1, 32'd5);
    wr(2'd0, mk(1, 0, 0, 0, 0, 0, 0, 0, 0, 1));
    tick(2);
    @(negedge clk);
    check("R2 first advance", 32'(count_val), 1);
    check("R14 count readback", rd_data, 1);
    phase = "R4";
    tick(16);
    @(negedge clk);
    check("R6 irq with flag and enable", 32'(ovf_irq), 1);
    tick(1);

    phase = "R5";
    dbg_mode = 1'b1;
    rd_addr = 2'd2;
    tick(2);
    wr(2'd2, 32'h0);
    @(negedge clk);
    check("R5 zero write keeps flag", rd_data, 32'h100);
    tick(1);
    wr(2'd2, 32'h100);
    @(negedge clk);
    check("R5 one write clears flag", rd_data, 0);
    check("R6 irq drops with flag", 32'(ovf_irq), 0);
    tick(1);
    dbg_mode = 1'b0;
    wr(2'd1, 32'd3);
    for (int i = 0; i < 16; i++) wr(2'd2, 32'h100);

    phase = "R3";
    rd_addr = 2'd3;
    wr(2'd1, 32'd2);
    wr(2'd0, mk(1, 2, 0, 0, 0, 0, 0, 0, 0, 1));
    tick(40);
    wr(2'd0, mk(1, 1, 0, 0, 0, 0, 0, 0, 0, 1));
    tick(20);

    phase = "R11";
    wr(2'd1, 32'd200);
    wr(2'd0, mk(1, 0, 0, 0, 0, 0, 0, 1, 0, 0));
    doze_mode = 1'b1;
    tick(2);
    @(negedge clk);
    cap = count_val;
    tick(5);
    @(negedge clk);
    check("R11 doze pause holds", 32'(count_val), 32'(cap));
    tick(1);
    doze_mode = 1'b0;
    dbg_mode = 1'b1;
    wr(2'd0, mk(1, 0, 0, 0, 0, 0, 0, 1, 1, 0));
    tick(8);
    dbg_mode = 1'b0;

    phase = "R13";
    wr(2'd0, mk(2, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    for (int i = 0; i < 4; i++) begin
      ext_clk = 1'b1; tick(2); ext_clk = 1'b0; tick(2);
    end
    rd_addr = 2'd0;
    wr(2'd0, 32'h0);
    tick(3);
    @(negedge clk);
    check("R13 mode still reads external", rd_data & 3, 2);
    tick(1);
    ext_clk = 1'b1;
    tick(1);
    @(negedge clk);
    check("R13 mode reads off after tick", rd_data & 3, 0);
    tick(1);
    ext_clk = 1'b0;
    tick(2);

    phase = "R7";
    rd_addr = 2'd3;
    wr(2'd0, mk(1, 0, 3, 1, 0, 0, 0, 0, 0, 0));
    tick(6);
    @(negedge clk);
    cap = count_val;
    tick(1);
    phase = "R12";
    trig_in[5] = 1'b1; tick(2); trig_in[5] = 1'b0; tick(2);
    @(negedge clk);
    check("R12 unselected trigger ignored", 32'(count_val), 32'(cap));
    check("R7 waits for trigger", 32'(count_val), 32'(cap));
    tick(1);
    phase = "R7";
    trig_in[3] = 1'b1;
    tick(1);
    trig_in[3] = 1'b0;
    tick(10);
    @(negedge clk);
    check("R7 counts after trigger", 32'(count_val), 32'(cap) + 10);
    tick(1);

    phase = "R8";
    wr(2'd0, 32'h0);
    tick(2);
    wr(2'd0, mk(1, 0, 7, 0, 1, 0, 0, 0, 0, 1));
    tick(20);
    trig_in[7] = 1'b1;
    tick(1);
    @(negedge clk);
    check("R8 reload to zero", 32'(count_val), 0);
    tick(1);
    trig_in[7] = 1'b0;
    wr(2'd1, 32'd9);
    for (int i = 0; i < 8; i++) begin
      tick(7 + i);
      trig_in[7] = 1'b1; tick(1); trig_in[7] = 1'b0;
    end

    phase = "R9";
    wr(2'd1, 32'd255);
    wr(2'd0, mk(1, 0, 2, 0, 0, 1, 0, 0, 0, 0));
    tick(5);
    trig_in[2] = 1'b1;
    tick(1);
    @(negedge clk);
    cap = count_val;
    tick(8);
    @(negedge clk);
    check("R9 pause while trigger high", 32'(count_val), 32'(cap));
    tick(1);
    trig_in[2] = 1'b0;
    tick(5);

    phase = "R10";
    wr(2'd1, 32'd4);
    wr(2'd2, 32'h100);
    wr(2'd0, mk(1, 0, 1, 0, 1, 0, 1, 0, 0, 1));
    trig_in[1] = 1'b1; tick(1); trig_in[1] = 1'b0;
    tick(20);
    @(negedge clk);
    check("R10 halted at zero", 32'(count_val), 0);
    check("R10 overflow flagged", 32'(ovf_irq), 1);
    tick(1);
    trig_in[1] = 1'b1; tick(1); trig_in[1] = 1'b0;
    tick(10);
    @(negedge clk);
    check("R10 stays halted", 32'(count_val), 0);
    tick(1);
    wr(2'd0, 32'h0);
    tick(2);
    wr(2'd0, mk(1, 0, 1, 0, 0, 0, 1, 0, 0, 1));
    tick(12);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule